// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel controlled over a byte-wide register bus with a 2-bit address. Offset 3 is the control port. The data port of this channel sits at the offset given by the `CH_ID` parameter, which defaults to 0. The other two data offsets belong to absent sibling channels.

Software first writes a control word that selects the channel, the access style and the counting mode. It then writes a 16-bit reload value as a low byte followed by a high byte. After the high byte arrives, the counter decrements once for each cycle in which the count-enable `tick` input is high. It drives a level output and a one-cycle interrupt pulse.

Three modes are available:
- **One-shot interrupt (mode 0):** the output is held low until terminal count.
- **Periodic rate generator (mode 2):** the counter reloads every N ticks.
- **Software strobe (mode 4):** the output dips low for one tick at terminal count.

A latch command freezes the count, so that two successive byte reads of the data port give a coherent value while the counter keeps running. Only binary counting is provided. A timer used for one-shot events is expected to be loaded with values from 0x000F to 0x7FFF.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is high, the interrupt pulse is low, the counter is stopped, and two reads of the data port return 0x00 and 0x00.
- R2: A control word is accepted only when written to offset 3 with bits 7:6 equal to `CH_ID`. Bits 5:4 = 11 selects low-then-high byte access and bits 5:4 = 00 is the latch command. Bits 3:1 give the mode: 000 = one-shot, 010 = rate, 100 = strobe. Bit 0 is not decoded. Any other channel, access or mode code is ignored. Writes to the other data offsets are ignored, and reads of them return 0x00.
- R3: An accepted mode word stops the counter and returns both byte pointers to the low byte. The count stays frozen until a low byte and then a high byte have been written to the data port. The high-byte write loads the count and starts counting.
- R4: In one-shot mode the output goes low on the mode word and on each completed load. It stays low while counting and goes high on the tick that brings the count from 1 to 0. That tick also raises one interrupt and stops the counter at 0.
- R5: In rate mode, with a load of N ≥ 2, the first interrupt follows the (N-1)th tick and later interrupts follow every N ticks. The output is low for exactly one tick per period, from count 1 until the reload.
- R6: In strobe mode the output stays high while counting. The tick that brings the count to 0 raises one interrupt, drives the output low and stops the counter. The next tick returns the output high.
- R7: A loaded value of 0x0000 counts as 65536: one tick after loading it, the count reads 0xFFFF.
- R8: A latch command copies the current count. The next two data reads return its low byte and then its high byte. A further latch command before the high byte has been read is ignored.
- R9: Without a pending latch, successive data reads alternate between the low byte and the high byte of the live count. Read data is registered and valid on the cycle after the read strobe.
- R10: The interrupt pulse lasts one clock cycle and appears only in the cycle after a clock in which `tick` was high.
- R11: In one-shot and strobe modes, any load from 0x000F to 0x7FFF gives exactly one interrupt, on the tick equal to the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick | input | 1 | Count enable, one decrement per high cycle |
| out_level | output | 1 | Timer output level |
| irq_pulse | output | 1 | One-cycle event pulse |

## Verification
Any wrong internal state in this block appears at the ports within a few cycles:
- **Byte pointers:** a wrong pointer swaps bytes on the very next load or read. The bench sees this as a count that is wrong by a factor of 256, or as a high byte where a low byte was expected.
- **Counter:** a stale run flag or a mis-decoded mode word shows on the following tick as a count that moved when it should have held, or the reverse.
- **Terminal and reload logic:** faults here show at the first period boundary. The interrupt arrives one tick early or late, or the output stays low for a tick too many.
- **Latch:** a snapshot that is overwritten or released too early is caught on the high-byte read that follows it.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    MODE_ONESHOT = 3'd0,
    MODE_RATE    = 3'd2,
    MODE_STROBE  = 3'd4
  } pit_mode_e;

  typedef struct packed {
    logic      mode_wr;
    logic      latch_cmd;
    pit_mode_e mode;
  } ctrl_cmd_t;

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
  import pit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CH_ID  = 0
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_cmd_t         cmd
);

  localparam int CH_HI  = DATA_W - 1;
  localparam int ACC_HI = DATA_W - 3;
  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LOHI  = 2'b11;

  logic [1:0] ch_field;
  logic [1:0] acc_field;
  logic [2:0] mode_field;
  logic       for_me;
  logic       mode_ok;
  logic       unused_bcd;

  always_comb begin
    ch_field   = wdata[CH_HI -: 2];
    acc_field  = wdata[ACC_HI -: 2];
    mode_field = wdata[3:1];
    unused_bcd = wdata[0];
    for_me     = wr_en && (ch_field == 2'(CH_ID));
    mode_ok    = (mode_field == MODE_ONESHOT) || (mode_field == MODE_RATE) ||
                 (mode_field == MODE_STROBE);
    cmd.latch_cmd = for_me && (acc_field == ACC_LATCH);
    cmd.mode_wr   = for_me && (acc_field == ACC_LOHI) && mode_ok;
    cmd.mode      = mode_ok ? pit_mode_e'(mode_field) : MODE_ONESHOT;
  end

endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  pit_mode_e         mode,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick,
  output logic [CNT_W:0]    count,
  output logic              running,
  output logic              hi_load,
  output pit_mode_e         cur_mode,
  output logic              out_level,
  output logic              irq_pulse
);

  localparam logic [CNT_W:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] ONE      = (CNT_W+1)'(1);
  localparam logic [CNT_W:0] TWO      = (CNT_W+1)'(2);

  logic              wr_hi;
  logic [BYTE_W-1:0] lo_hold;
  logic [CNT_W:0]    reload;
  logic              strobe_q;
  logic [CNT_W-1:0]  new_val;
  logic [CNT_W:0]    load_val;

  always_comb begin
    new_val  = {wdata, lo_hold};
    load_val = (new_val == '0) ? FULL_CNT : {1'b0, new_val};
    hi_load  = data_wr && wr_hi && !mode_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode  <= MODE_ONESHOT;
      wr_hi     <= 1'b0;
      lo_hold   <= '0;
      reload    <= '0;
      count     <= '0;
      running   <= 1'b0;
      out_level <= 1'b1;
      irq_pulse <= 1'b0;
      strobe_q  <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      if (mode_wr) begin
        cur_mode  <= mode;
        wr_hi     <= 1'b0;
        running   <= 1'b0;
        strobe_q  <= 1'b0;
        out_level <= (mode != MODE_ONESHOT);
      end else if (data_wr) begin
        if (!wr_hi) begin
          lo_hold <= wdata;
          wr_hi   <= 1'b1;
        end else begin
          wr_hi     <= 1'b0;
          reload    <= load_val;
          count     <= load_val;
          running   <= 1'b1;
          strobe_q  <= 1'b0;
          out_level <= (cur_mode != MODE_ONESHOT);
        end
      end else if (tick) begin
        if (strobe_q) begin
          out_level <= 1'b1;
          strobe_q  <= 1'b0;
        end
        if (running) begin
          case (cur_mode)
            MODE_RATE: begin
              if (count == TWO) begin
                count     <= ONE;
                out_level <= 1'b0;
                irq_pulse <= 1'b1;
              end else if (count == ONE) begin
                count     <= reload;
                out_level <= 1'b1;
              end else begin
                count <= count - ONE;
              end
            end
            MODE_STROBE: begin
              if (count == ONE) begin
                count     <= '0;
                out_level <= 1'b0;
                irq_pulse <= 1'b1;
                running   <= 1'b0;
                strobe_q  <= 1'b1;
              end else begin
                count <= count - ONE;
              end
            end
            default: begin
              if (count == ONE) begin
                count     <= '0;
                out_level <= 1'b1;
                irq_pulse <= 1'b1;
                running   <= 1'b0;
              end else begin
                count <= count - ONE;
              end
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pit_readback.sv
module pit_readback #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic              latch_cmd,
  input  logic              rd_ch,
  input  logic              rd_other,
  input  logic [CNT_W-1:0]  count_lo,
  output logic [BYTE_W-1:0] rdata,
  output logic              latched
);

  logic             rd_hi;
  logic [CNT_W-1:0] snap;
  logic [CNT_W-1:0] src;

  always_comb src = latched ? snap : count_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      rd_hi   <= 1'b0;
      latched <= 1'b0;
      snap    <= '0;
    end else if (mode_wr) begin
      rd_hi   <= 1'b0;
      latched <= 1'b0;
    end else if (latch_cmd) begin
      if (!latched) begin
        snap    <= count_lo;
        latched <= 1'b1;
        rd_hi   <= 1'b0;
      end
    end else if (rd_ch) begin
      rdata <= rd_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
      rd_hi <= ~rd_hi;
      if (latched && rd_hi) latched <= 1'b0;
    end else if (rd_other) begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int CH_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  output logic              out_level,
  output logic              irq_pulse
);

  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(CH_ID);

  ctrl_cmd_t      ctrl_cmd;
  logic           ctrl_wr;
  logic           ctrl_mode_wr;
  logic           data_wr;
  logic           rd_ch;
  logic           rd_other;
  logic [CNT_W:0] cnt_value;
  logic           cnt_running;
  logic           cnt_hi_load;
  pit_mode_e      cnt_mode;
  logic           rb_latched;

  always_comb begin
    ctrl_wr      = bus_wr && (bus_addr == ADDR_CTRL);
    data_wr      = bus_wr && (bus_addr == ADDR_DATA);
    rd_ch        = bus_rd && (bus_addr == ADDR_DATA);
    rd_other     = bus_rd && (bus_addr != ADDR_DATA);
    ctrl_mode_wr = ctrl_cmd.mode_wr;
  end

  pit_ctrl_decode #(.DATA_W(DATA_W), .CH_ID(CH_ID)) u_decode (
    .wr_en (ctrl_wr),
    .wdata (bus_wdata),
    .cmd   (ctrl_cmd)
  );

  pit_counter #(.BYTE_W(DATA_W), .CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (ctrl_mode_wr),
    .mode      (ctrl_cmd.mode),
    .data_wr   (data_wr),
    .wdata     (bus_wdata),
    .tick      (tick),
    .count     (cnt_value),
    .running   (cnt_running),
    .hi_load   (cnt_hi_load),
    .cur_mode  (cnt_mode),
    .out_level (out_level),
    .irq_pulse (irq_pulse)
  );

  pit_readback #(.BYTE_W(DATA_W), .CNT_W(CNT_W)) u_readback (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (ctrl_mode_wr),
    .latch_cmd (ctrl_cmd.latch_cmd),
    .rd_ch     (rd_ch),
    .rd_other  (rd_other),
    .count_lo  (cnt_value[CNT_W-1:0]),
    .rdata     (bus_rdata),
    .latched   (rb_latched)
  );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           irq_pulse,
  input logic           out_level,
  input logic           mode_wr,
  input logic           running,
  input logic           hi_load,
  input logic [CNT_W:0] count,
  input pit_mode_e      mode
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst) irq_pulse |=> !irq_pulse); // R10
  AST_IRQ_FROM_TICK: assert property (@(posedge clk) disable iff (rst) irq_pulse |-> $past(tick)); // R10
  AST_STOP_ON_MODE: assert property (@(posedge clk) disable iff (rst) mode_wr |=> !running); // R3
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst) (!running && !hi_load) |=> $stable(count)); // R3
  AST_ONESHOT_OUT_LOW: assert property (@(posedge clk) disable iff (rst) (running && mode == MODE_ONESHOT) |-> !out_level); // R4
  AST_RATE_NONZERO: assert property (@(posedge clk) disable iff (rst) (running && mode == MODE_RATE) |-> (count != '0)); // R5

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .irq_pulse (irq_pulse),
  .out_level (out_level),
  .mode_wr   (ctrl_mode_wr),
  .running   (cnt_running),
  .hi_load   (cnt_hi_load),
  .count     (cnt_value),
  .mode      (cnt_mode)
);

// File: tb/pit_channel_bench.sv
`timescale 1ns/1ps
module pit_channel_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tick = 1'b0;
  logic       out_level;
  logic       irq_pulse;

  int total = 0;
  int bad = 0;
  int tick_idx, irq_cnt, first_irq, low_cnt, first_low;

  always #4 clk = ~clk;

  pit_channel u_pit_channel (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .out_level(out_level), .irq_pulse(irq_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd0, hi);
    v = {hi, lo};
  endtask

  task automatic load16(input logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd0, v[15:8]);
  endtask

  task automatic clear_stats();
    tick_idx = 0; irq_cnt = 0; first_irq = 0; low_cnt = 0; first_low = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      tick_idx++;
      if (irq_pulse) begin
        irq_cnt++;
        if (first_irq == 0) first_irq = tick_idx;
      end
      if (!out_level) begin
        low_cnt++;
        if (first_low == 0) first_low = tick_idx;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 out", int'(out_level), 1);
    check("R1 irq", int'(irq_pulse), 0);
    rd16(v);
    check("R1 count", int'(v), 0);

    // R4 one-shot sweep
    for (int n = 1; n <= 20; n++) begin
      wr(2'd3, 8'h30);
      if (n == 1) check("R4 out low on mode word", int'(out_level), 0);
      load16(16'(n));
      clear_stats();
      ticks(n + 2);
      check("R4 first irq tick", first_irq, n);
      check("R4 irq count", irq_cnt, 1);
      check("R4 low ticks", low_cnt, n - 1);
      check("R4 out high at end", int'(out_level), 1);
      rd16(v);
      check("R4 stops at 0", int'(v), 0);
    end

    // R10 pulse one cycle
    wr(2'd3, 8'h30);
    load16(16'd1);
    clear_stats();
    ticks(1);
    check("R10 irq seen", irq_cnt, 1);
    @(negedge clk);
    check("R10 irq dropped", int'(irq_pulse), 0);

    // R5 rate sweep
    for (int n = 2; n <= 12; n++) begin
      wr(2'd3, 8'h34);
      check("R5 out high on mode word", int'(out_level), 1);
      load16(16'(n));
      clear_stats();
      ticks(3 * n);
      check("R5 first irq", first_irq, n - 1);
      check("R5 irq count", irq_cnt, 3);
      check("R5 low ticks", low_cnt, 3);
      check("R5 first low", first_low, n - 1);
    end

    // R6 and R11 strobe sweep
    for (int n = 15; n <= 24; n++) begin
      wr(2'd3, 8'h38);
      load16(16'(n));
      clear_stats();
      ticks(n + 3);
      check("R6 irq tick", first_irq, n);
      check("R6 irq count", irq_cnt, 1);
      check("R6 one low tick", low_cnt, 1);
      check("R6 low at terminal", first_low, n);
    end

    // R3 stop and resume
    wr(2'd3, 8'h30);
    load16(16'h0100);
    ticks(3);
    wr(2'd3, 8'h30);
    ticks(5);
    rd16(v);
    check("R3 frozen after mode word", int'(v), 16'h00FD);
    wr(2'd0, 8'h10);
    ticks(3);
    rd16(v);
    check("R3 frozen after low byte", int'(v), 16'h00FD);
    wr(2'd0, 8'h00);
    ticks(2);
    rd16(v);
    check("R3 resumes after high byte", int'(v), 16'h000E);

    // R3 pointer reset by control word
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h22);
    wr(2'd3, 8'h30);
    load16(16'h0007);
    rd16(v);
    check("R3 pointer reset", int'(v), 16'h0007);

    // R2 ignored words and ports
    wr(2'd3, 8'h30);
    load16(16'd100);
    ticks(10);
    wr(2'd3, 8'h70);
    wr(2'd3, 8'h10);
    wr(2'd3, 8'h36);
    check("R2 out unchanged", int'(out_level), 0);
    ticks(2);
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h55);
    ticks(1);
    rd16(v);
    check("R2 count continues", int'(v), 87);
    rd(2'd1, b);
    check("R2 other port reads zero", int'(b), 0);
    ticks(1);
    rd16(v);
    check("R2 pointer untouched", int'(v), 86);

    // R7 zero means 65536
    wr(2'd3, 8'h30);
    load16(16'h0000);
    ticks(1);
    rd16(v);
    check("R7 zero load", int'(v), 16'hFFFF);

    // R8 and R9 latch and live reads
    wr(2'd3, 8'h34);
    load16(16'd1000);
    ticks(10);
    wr(2'd3, 8'h00);
    ticks(5);
    wr(2'd3, 8'h00);
    rd16(v);
    check("R8 snapshot", int'(v), 990);
    rd16(v);
    check("R9 live read", int'(v), 985);
    wr(2'd3, 8'h00);
    rd(2'd0, b);
    check("R8 snapshot low", int'(b), 985 & 8'hFF);
    ticks(3);
    wr(2'd3, 8'h00);
    rd(2'd0, b);
    check("R8 second latch ignored", int'(b), 985 >> 8);
    rd16(v);
    check("R9 live after latch", int'(v), 982);

    // R11 top of one-shot range
    wr(2'd3, 8'h38);
    load16(16'h7FFF);
    clear_stats();
    ticks(16'h7FFF + 1);
    check("R11 irq at 0x7FFF", first_irq, 16'h7FFF);
    check("R11 single irq", irq_cnt, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule